// File: doc/BRIEF.md
# Science Data Test-Pattern Formatter

This block sits on the science-data read path, between the source that supplies science bytes and the CPU read port. Each science-data read strobe produces one registered output transfer. That transfer is either the real byte offered by the source or a synthetic built-in-test byte. A test-enable input and a 3-bit pattern code choose between them. The synthetic patterns are:

- constant bytes;
- even/odd alternating bytes;
- an incrementing counter;
- the bitwise complement of that counter.

A nibble mode splits every byte into two transfers, high nibble first. Each nibble is copied onto both halves of the 8-bit bus. A byte index counts completed bytes. It decides whether a byte is even or odd, it supplies the counter pattern, and it is brought out for the transfer counter. A block-start pulse puts the index back to zero at the start of each science block.

Top module: `sci_pattern_fmt`

## Requirements
- R1: After reset, `rd_data` is 8'h00, `byte_idx` is 0, `src_take` is 0, and the next transfer is the first one of a byte.
- R2: When `test_en` is 0, the transfer carries `src_data`, whatever the value of `pat_sel`.
- R3: When `test_en` is 1 and `pat_sel` is 3'b000 or 3'b111, the transfer carries `src_data`.
- R4: With `test_en` = 1, code 3'b001 gives 8'h00 on an even byte index and 8'hFF on an odd one. Code 3'b110 gives 8'hFF on an even index and 8'h00 on an odd one. Parity is taken from bit 0 of `byte_idx`.
- R5: With `test_en` = 1, code 3'b010 gives 8'hAA and code 3'b011 gives 8'h55.
- R6: With `test_en` = 1, code 3'b100 gives the low 8 bits of the byte's index, zero-extended when the index is narrower than 8 bits. Code 3'b101 gives the bitwise complement of that value.
- R7: When `nib_mode` is 1, each byte takes two reads. The first read gives {b[7:4],b[7:4]} and the second gives {b[3:0],b[3:0]}, where b is the byte selected by R2 to R6.
- R8: `byte_idx` grows by one for each completed byte: on every accepted read in byte mode, and on the second read in nibble mode. In the cycle after each completed byte, `src_take` is 1 for exactly one cycle.
- R9: `blk_start` clears `byte_idx` and returns to the first nibble. A read strobe in the same cycle as `blk_start` is ignored, so `rd_data` holds its value. The first byte of a block is index 0, which is even.
- R10: When neither `rd_stb` nor `blk_start` is asserted, `rd_data` and `byte_idx` hold their values.
- R11: `byte_idx` wraps from 2^IDX_W-1 to 0, and the counter pattern follows the wrap.
- R12: Results appear one clock after the edge at which `rd_stb` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_start | input | 1 | Start of a science block: clears the byte index and the nibble phase |
| rd_stb | input | 1 | One-cycle science-data read strobe |
| test_en | input | 1 | 0 selects real data, 1 selects synthetic data |
| pat_sel | input | 3 | Test-pattern code |
| nib_mode | input | 1 | 0 selects byte transfers, 1 selects mirrored nibble transfers |
| src_data | input | 8 | Real byte from the source, held until `src_take` |
| rd_data | output | 8 | Registered transfer value |
| src_take | output | 1 | One-cycle pulse: the current real byte has been consumed |
| byte_idx | output | IDX_W | Index of the next byte in the block |

## Verification
The bench builds the block with IDX_W = 5, so the index wraps after 32 bytes. This makes the wrap and the counter pattern restarting at zero reachable within a short directed run. Because the index is narrower than 8 bits, it also checks the zero-extension of the counter and its complement, where the upper three bits are always 1. Each pattern code is applied over several consecutive bytes, in both byte and nibble mode, so the even/odd alternation and the nibble ordering are both seen.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;

  typedef enum logic [2:0] {
    PAT_REAL0  = 3'b000,
    PAT_EVN00  = 3'b001,
    PAT_CHK_AA = 3'b010,
    PAT_CHK_55 = 3'b011,
    PAT_CNT    = 3'b100,
    PAT_NCNT   = 3'b101,
    PAT_EVNFF  = 3'b110,
    PAT_REAL7  = 3'b111
  } pat_code_e;

  // Byte chosen for one transfer, before nibble formatting.
  function automatic logic [7:0] pattern_byte(
    input logic       synth,
    input logic [2:0] code,
    input logic       odd,
    input logic [7:0] cnt,
    input logic [7:0] real_b
  );
    logic [7:0] r;
    if (!synth) begin
      r = real_b;
    end else begin
      case (pat_code_e'(code))
        PAT_EVN00:  r = odd ? 8'hFF : 8'h00;
        PAT_CHK_AA: r = 8'hAA;
        PAT_CHK_55: r = 8'h55;
        PAT_CNT:    r = cnt;
        PAT_NCNT:   r = ~cnt;
        PAT_EVNFF:  r = odd ? 8'h00 : 8'hFF;
        default:    r = real_b;
      endcase
    end
    return r;
  endfunction

  // Lane layout on the bus: whole byte, or one nibble on both halves.
  function automatic logic [7:0] lane_byte(
    input logic       nib,
    input logic       second,
    input logic [7:0] b
  );
    logic [3:0] n;
    n = second ? b[3:0] : b[7:4];
    return nib ? {n, n} : b;
  endfunction

endpackage

// File: rtl/sfmt_index.sv
module sfmt_index #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             nib_mode,
  output logic [IDX_W-1:0] idx,
  output logic             half,
  output logic             done
);

  assign done = step && (!nib_mode || half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      half <= 1'b0;
    end else if (clr) begin
      idx  <= '0;
      half <= 1'b0;
    end else if (step) begin
      half <= nib_mode ? ~half : 1'b0;
      if (done) idx <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/sfmt_pattern.sv
module sfmt_pattern #(
  parameter int IDX_W = 16
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             test_en,
  input  logic [2:0]       pat_sel,
  input  logic [7:0]       src_data,
  output logic [7:0]       pat_byte
);
  import sfmt_pkg::*;

  logic [7:0] cnt8;

  generate
    if (IDX_W >= 8) begin : g_wide
      assign cnt8 = idx[7:0];
    end else begin : g_narrow
      assign cnt8 = {{(8-IDX_W){1'b0}}, idx};
    end
  endgenerate

  assign pat_byte = pattern_byte(test_en, pat_sel, idx[0], cnt8, src_data);

endmodule

// File: rtl/sfmt_lane.sv
module sfmt_lane (
  input  logic       nib_mode,
  input  logic       half,
  input  logic [7:0] in_byte,
  output logic [7:0] lane
);
  import sfmt_pkg::*;

  assign lane = lane_byte(nib_mode, half, in_byte);

endmodule

// File: rtl/sci_pattern_fmt.sv
module sci_pattern_fmt #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_start,
  input  logic             rd_stb,
  input  logic             test_en,
  input  logic [2:0]       pat_sel,
  input  logic             nib_mode,
  input  logic [7:0]       src_data,
  output logic [7:0]       rd_data,
  output logic             src_take,
  output logic [IDX_W-1:0] byte_idx
);

  logic       rd_accept;
  logic       byte_done;
  logic       nib_half;
  logic [7:0] pat_byte;
  logic [7:0] lane_val;

  assign rd_accept = rd_stb && !blk_start;

  sfmt_index #(.IDX_W(IDX_W)) u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (blk_start),
    .step     (rd_accept),
    .nib_mode (nib_mode),
    .idx      (byte_idx),
    .half     (nib_half),
    .done     (byte_done)
  );

  sfmt_pattern #(.IDX_W(IDX_W)) u_pattern (
    .idx      (byte_idx),
    .test_en  (test_en),
    .pat_sel  (pat_sel),
    .src_data (src_data),
    .pat_byte (pat_byte)
  );

  sfmt_lane u_lane (
    .nib_mode (nib_mode),
    .half     (nib_half),
    .in_byte  (pat_byte),
    .lane     (lane_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= 8'h00;
      src_take <= 1'b0;
    end else begin
      src_take <= byte_done;
      if (rd_accept) rd_data <= lane_val;
    end
  end

endmodule

// File: rtl/sfmt_checker.sv
module sfmt_checker #(
  parameter int IDX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             blk_start,
  input logic             rd_stb,
  input logic             test_en,
  input logic [2:0]       pat_sel,
  input logic             nib_mode,
  input logic [7:0]       rd_data,
  input logic             src_take,
  input logic [IDX_W-1:0] byte_idx,
  input logic             rd_accept,
  input logic             byte_done
);

  AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> byte_idx == '0);                                      // R9

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> byte_idx == $past(byte_idx) + 1'b1);                  // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !blk_start) |=> ($stable(byte_idx) && $stable(rd_data))); // R10

  AST_BLOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> $stable(rd_data));                                    // R9

  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    src_take |=> !src_take || $past(byte_done));                        // R8

  AST_NIB_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_accept && nib_mode) |=> rd_data[7:4] == rd_data[3:0]);          // R7

  AST_CONST_AA: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_accept && test_en && pat_sel == 3'b010 && !nib_mode) |=> rd_data == 8'hAA); // R5

  AST_CONST_55: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_accept && test_en && pat_sel == 3'b011 && !nib_mode) |=> rd_data == 8'h55); // R5

endmodule

bind sci_pattern_fmt sfmt_checker #(.IDX_W(IDX_W)) u_sfmt_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .blk_start (blk_start),
  .rd_stb    (rd_stb),
  .test_en   (test_en),
  .pat_sel   (pat_sel),
  .nib_mode  (nib_mode),
  .rd_data   (rd_data),
  .src_take  (src_take),
  .byte_idx  (byte_idx),
  .rd_accept (rd_accept),
  .byte_done (byte_done)
);

// File: tb/tb_sci_pattern_fmt.sv
module tb_sci_pattern_fmt;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 5;
  localparam int WRAP = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          blk_start = 1'b0;
  logic          rd_stb = 1'b0;
  logic          test_en = 1'b0;
  logic [2:0]    pat_sel = 3'b000;
  logic          nib_mode = 1'b0;
  logic [7:0]    src_data = 8'h00;
  logic [7:0]    rd_data;
  logic          src_take;
  logic [IW-1:0] byte_idx;

  int n_chk = 0;
  int n_bad = 0;
  int exp_idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sci_pattern_fmt #(.IDX_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .rd_stb(rd_stb),
    .test_en(test_en), .pat_sel(pat_sel), .nib_mode(nib_mode),
    .src_data(src_data), .rd_data(rd_data), .src_take(src_take),
    .byte_idx(byte_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Independent model of the synthetic byte for a given index.
  function automatic int model_byte(input bit synth, input int code, input int idx, input int src);
    int c8;
    c8 = idx & 8'hFF;
    if (!synth || code == 0 || code == 7) return src;
    if (code == 2) return 8'hAA;
    if (code == 3) return 8'h55;
    if (code == 4) return c8;
    if (code == 5) return 8'hFF - c8;
    if (code == 1) return (idx % 2 == 1) ? 8'hFF : 8'h00;
    return (idx % 2 == 0) ? 8'hFF : 8'h00;
  endfunction

  // One read strobe; returns after the result is visible (R12).
  task automatic do_read();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic new_block();
    @(negedge clk); blk_start = 1'b1;
    @(negedge clk); blk_start = 1'b0;
    exp_idx = 0;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 0);
    chk("R1 byte_idx", byte_idx, 0);
    chk("R1 src_take", src_take, 0);
  endtask

  task automatic t_real();
    test_en = 1'b0;
    nib_mode = 1'b0;
    for (int k = 0; k < 4; k++) begin
      pat_sel = 3'(k + 2);
      src_data = 8'(8'h3C + 17 * k);
      do_read();
      exp_idx++;
      chk("R2 real passthru", rd_data, model_byte(0, k + 2, exp_idx - 1, int'(src_data)));
      chk("R8 take pulse", src_take, 1);
      chk("R8 index step", byte_idx, exp_idx % WRAP);
      @(negedge clk);
      chk("R8 take one cycle", src_take, 0);
    end
    test_en = 1'b1;
    pat_sel = 3'b000; src_data = 8'hC7; do_read(); exp_idx++;
    chk("R3 code 000", rd_data, 8'hC7);
    pat_sel = 3'b111; src_data = 8'h1E; do_read(); exp_idx++;
    chk("R3 code 111", rd_data, 8'h1E);
  endtask

  task automatic t_patterns();
    test_en = 1'b1;
    nib_mode = 1'b0;
    src_data = 8'h99;
    for (int code = 1; code <= 6; code++) begin
      new_block();
      pat_sel = 3'(code);
      for (int b = 0; b < 5; b++) begin
        do_read();
        case (code)
          1, 6:    chk("R4 even/odd", rd_data, model_byte(1, code, b, 8'h99));
          2, 3:    chk("R5 constant", rd_data, model_byte(1, code, b, 8'h99));
          default: chk("R6 counter", rd_data, model_byte(1, code, b, 8'h99));
        endcase
      end
    end
    exp_idx = 5;
  endtask

  task automatic t_nibble();
    new_block();
    nib_mode = 1'b1;
    test_en = 1'b0;
    src_data = 8'hB4;
    do_read();
    chk("R7 high nibble first", rd_data, 8'hBB);
    chk("R8 no step mid-byte", byte_idx, 0);
    chk("R8 no take mid-byte", src_take, 0);
    do_read();
    chk("R7 low nibble second", rd_data, 8'h44);
    chk("R8 step after second nibble", byte_idx, 1);
    chk("R8 take after second nibble", src_take, 1);
    test_en = 1'b1; pat_sel = 3'b101;
    do_read();
    chk("R7 R6 ncnt high", rd_data, 8'hFF);
    do_read();
    chk("R7 R6 ncnt low", rd_data, 8'hEE);
    pat_sel = 3'b001;
    do_read(); chk("R7 R4 even byte high", rd_data, 8'h00);
    do_read(); chk("R7 R4 even byte low", rd_data, 8'h00);
    do_read(); chk("R7 R4 odd byte high", rd_data, 8'hFF);
    // restart mid-byte: phase must return to high nibble
    new_block();
    pat_sel = 3'b000; src_data = 8'h5A;
    do_read();
    chk("R9 phase cleared", rd_data, 8'h55);
    do_read();
    chk("R9 low after restart", rd_data, 8'hAA);
    nib_mode = 1'b0;
    exp_idx = 1;
  endtask

  task automatic t_block_hold();
    test_en = 1'b1; pat_sel = 3'b010; nib_mode = 1'b0;
    do_read();
    chk("R5 AA before hold", rd_data, 8'hAA);
    pat_sel = 3'b011;
    @(negedge clk); blk_start = 1'b1; rd_stb = 1'b1;
    @(negedge clk); blk_start = 1'b0; rd_stb = 1'b0;
    chk("R9 read ignored during block start", rd_data, 8'hAA);
    chk("R9 index cleared", byte_idx, 0);
    repeat (3) @(negedge clk);
    chk("R10 idle data hold", rd_data, 8'hAA);
    chk("R10 idle index hold", byte_idx, 0);
    pat_sel = 3'b001; do_read();
    chk("R9 first byte even", rd_data, 8'h00);
    exp_idx = 1;
  endtask

  task automatic t_wrap();
    new_block();
    test_en = 1'b1; pat_sel = 3'b100; nib_mode = 1'b0;
    for (int b = 0; b < WRAP; b++) begin
      do_read();
      chk("R6 counter value", rd_data, b);
    end
    chk("R11 index wrapped", byte_idx, 0);
    do_read();
    chk("R11 counter restarts", rd_data, 0);
    pat_sel = 3'b101; do_read();
    chk("R11 R6 ncnt after wrap", rd_data, 8'hFE);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_real();
    t_patterns();
    t_nibble();
    t_block_hold();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule